// File: doc/BRIEF.md
# Clause 22 Indirect Extended-Register Bridge

This block lets a host reach a large extended register space through the small management register window of a Clause 22 PHY. The management interface delivers decoded register accesses to the block as a strobe, a 5-bit register number and 16-bit data. The block owns two of those registers, a control word and a data word, and drives an address, write-data and write-strobe port into an extended register bank. The bank returns read data combinationally.

The control word holds an access kind and a target device number. In pointer mode, a data-word write loads a 16-bit bank pointer and a data-word read returns it. In the three transfer modes, data-word accesses go to the bank location the pointer names. Two of the transfer modes advance the pointer after each access. One advances it after reads and after writes. The other advances it only after writes. Accesses are honoured only while the device number selects this bridge's own device.

To write one extended register, the host sets the control word to pointer mode and writes the register number to the data word. It then sets the control word to a transfer mode and writes the value to the data word. A read uses the same first three steps and then reads the data word. If a write strobe and a read strobe arrive in the same cycle, the write is carried out and the read returns zero.

Top module: `mmd_indirect_bridge`

## Requirements
- R1: After reset the control word reads 0x0000, the bank pointer (visible on `ext_addr`) is 0x0000, and `ext_we` is low.
- R2: Register 0x0D is the control word. A write stores bits 15:14 (access kind) and 4:0 (device number), and bits 13:5 always read back as zero. A read returns the last value stored.
- R3: The access kinds are 00 = pointer, 01 = transfer, 10 = transfer with advance on read and write, and 11 = transfer with advance on write only. In kind 00, with device number 0x1F, a write to register 0x0E loads the pointer and a read of 0x0E returns the pointer. Neither access drives `ext_we`.
- R4: In a transfer kind with device 0x1F, a write to 0x0E raises `ext_we` for that cycle only, with `ext_addr` equal to the pointer and `ext_wdata` equal to the written value. In kind 01 the pointer does not change.
- R5: In a transfer kind with device 0x1F, a read of 0x0E returns the bank word at the pointer.
- R6: In kind 10, the pointer advances by one after each data-word read and after each data-word write.
- R7: In kind 11, the pointer advances by one after each data-word write. Reads leave it unchanged.
- R8: The pointer wraps from 0xFFFF to 0x0000 when it advances.
- R9: When the device number is not 0x1F, data-word writes change neither the bank nor the pointer, data-word reads return 0x0000 and do not advance the pointer, and pointer loads are ignored.
- R10: Accesses to any register number other than 0x0D and 0x0E change no state, and reads of them return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Management register write strobe |
| reg_rd | input | 1 | Management register read strobe |
| reg_addr | input | 5 | Management register number |
| reg_wdata | input | 16 | Management write data |
| reg_rdata | output | 16 | Management read data, valid while `reg_rd` is high |
| ext_addr | output | 16 | Extended bank address (the pointer) |
| ext_wdata | output | 16 | Extended bank write data |
| ext_we | output | 1 | Extended bank write strobe |
| ext_rdata | input | 16 | Extended bank read data at `ext_addr` |

## Verification
The hardest situation to reach is the pointer wrapping across 0xFFFF while advancing. It is reached only through a chain of steps: a pointer-mode load of 0xFFFF, a switch to a write-advancing kind, a data write, and then a return to pointer mode so that the pointer can be read back. The vector table builds exactly that chain. The same chaining is used to show that a foreign device number blocks writes, reads, advances and pointer loads. After the device number is restored, the bench reads both the untouched bank word and the unchanged pointer.

// File: rtl/mmd_bridge_pkg.sv
package mmd_bridge_pkg;

    localparam int DATA_W = 16;
    localparam int REG_AW = 5;

    typedef enum logic [1:0] {
        ACC_PTR      = 2'b00,
        ACC_XFER     = 2'b01,
        ACC_XFER_RW  = 2'b10,
        ACC_XFER_WR  = 2'b11
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e   kind;
        logic [8:0]  rsvd;
        logic [4:0]  dev;
    } ctrl_word_t;

    typedef enum logic [1:0] {
        RSEL_ZERO,
        RSEL_CTRL,
        RSEL_PTR,
        RSEL_BANK
    } rsel_e;

    // Whether a data-word access of the given direction advances the pointer.
    function automatic logic advances(acc_kind_e k, logic is_write);
        case (k)
            ACC_XFER_RW: return 1'b1;
            ACC_XFER_WR: return is_write;
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mmd_ctrl_reg.sv
module mmd_ctrl_reg
    import mmd_bridge_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] kind_in,
    input  logic [4:0] dev_in,
    output ctrl_word_t ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{kind: ACC_PTR, rsvd: '0, dev: '0};
        end else if (wr_en) begin
            ctrl_q <= '{kind: acc_kind_e'(kind_in), rsvd: '0, dev: dev_in};
        end
    end

    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_q));

endmodule

// File: rtl/mmd_ptr_unit.sv
module mmd_ptr_unit #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             inc,
    output logic [PTR_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (inc) begin
            ptr <= ptr + 1'b1;
        end
    end

    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        load |=> ptr == $past(load_val));

    a_r6_advance: assert property (@(posedge clk) disable iff (rst)
        (inc && !load) |=> ptr == $past(ptr) + 1'b1);

    a_r9_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !inc) |=> $stable(ptr));

endmodule

// File: rtl/mmd_access_dec.sv
module mmd_access_dec
    import mmd_bridge_pkg::*;
#(
    parameter logic [REG_AW-1:0] CTRL_REG = 5'h0D,
    parameter logic [REG_AW-1:0] DATA_REG = 5'h0E,
    parameter logic [4:0]        OWN_DEV  = 5'h1F
) (
    input  acc_kind_e         kind,
    input  logic [4:0]        dev,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    output logic              ctrl_we,
    output logic              ptr_load,
    output logic              ptr_inc,
    output logic              bank_we,
    output rsel_e             rsel
);

    logic hit_ctrl, hit_data, dev_ok, ptr_mode, rd_only;

    always_comb begin
        hit_ctrl = (reg_addr == CTRL_REG);
        hit_data = (reg_addr == DATA_REG);
        dev_ok   = (dev == OWN_DEV);
        ptr_mode = (kind == ACC_PTR);
        rd_only  = reg_rd && !reg_wr;

        ctrl_we  = reg_wr && hit_ctrl;
        ptr_load = reg_wr && hit_data && dev_ok && ptr_mode;
        bank_we  = reg_wr && hit_data && dev_ok && !ptr_mode;
        ptr_inc  = hit_data && dev_ok && !ptr_mode &&
                   ((reg_wr && advances(kind, 1'b1)) ||
                    (rd_only && advances(kind, 1'b0)));

        rsel = RSEL_ZERO;
        if (rd_only && hit_ctrl) begin
            rsel = RSEL_CTRL;
        end else if (rd_only && hit_data && dev_ok) begin
            rsel = ptr_mode ? RSEL_PTR : RSEL_BANK;
        end
    end

endmodule

// File: rtl/mmd_indirect_bridge.sv
module mmd_indirect_bridge
    import mmd_bridge_pkg::*;
#(
    parameter logic [REG_AW-1:0] CTRL_REG = 5'h0D,
    parameter logic [REG_AW-1:0] DATA_REG = 5'h0E,
    parameter logic [4:0]        OWN_DEV  = 5'h1F,
    parameter int                PTR_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [PTR_W-1:0]  ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    output logic              ext_we,
    input  logic [DATA_W-1:0] ext_rdata
);

    ctrl_word_t       ctrl_q;
    logic             ctrl_we, ptr_load, ptr_inc, bank_we;
    rsel_e            rsel;
    logic [PTR_W-1:0] ptr;

    mmd_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctrl_we),
        .kind_in (reg_wdata[15:14]),
        .dev_in  (reg_wdata[4:0]),
        .ctrl_q  (ctrl_q)
    );

    mmd_access_dec #(
        .CTRL_REG (CTRL_REG),
        .DATA_REG (DATA_REG),
        .OWN_DEV  (OWN_DEV)
    ) u_dec (
        .kind     (ctrl_q.kind),
        .dev      (ctrl_q.dev),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .ctrl_we  (ctrl_we),
        .ptr_load (ptr_load),
        .ptr_inc  (ptr_inc),
        .bank_we  (bank_we),
        .rsel     (rsel)
    );

    mmd_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (reg_wdata[PTR_W-1:0]),
        .inc      (ptr_inc),
        .ptr      (ptr)
    );

    assign ext_addr  = ptr;
    assign ext_wdata = reg_wdata;
    assign ext_we    = bank_we;

    always_comb begin
        case (rsel)
            RSEL_CTRL: reg_rdata = ctrl_q;
            RSEL_PTR:  reg_rdata = DATA_W'(ptr);
            RSEL_BANK: reg_rdata = ext_rdata;
            default:   reg_rdata = '0;
        endcase
    end

    a_r4_we_source: assert property (@(posedge clk) disable iff (rst)
        ext_we |-> (reg_wr && reg_addr == DATA_REG));

    a_r4_we_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (ext_we && !$past(reg_wr)) |-> !$past(ext_we));

    a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && reg_addr == CTRL_REG) |-> reg_rdata[13:5] == '0);

    a_r10_other_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr != CTRL_REG && reg_addr != DATA_REG) |-> reg_rdata == '0);

    a_r7_no_read_advance: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.kind == ACC_XFER_WR && reg_rd && !reg_wr) |=> $stable(ext_addr));

endmodule

// File: tb/mmd_indirect_bridge_tb.sv
module mmd_indirect_bridge_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] ext_addr;
    logic [15:0] ext_wdata;
    logic        ext_we;
    logic [15:0] ext_rdata;

    logic [15:0] mem [64];
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mmd_indirect_bridge u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ext_addr  (ext_addr),
        .ext_wdata (ext_wdata),
        .ext_we    (ext_we),
        .ext_rdata (ext_rdata)
    );

    // Bank model: 64 words, indexed by low pointer bits, preset on reset.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) mem[i] <= 16'hA000 + 16'(i);
        end else if (ext_we) begin
            mem[ext_addr[5:0]] <= ext_wdata;
        end
    end
    assign ext_rdata = mem[ext_addr[5:0]];

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #2 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Entry: [41] read, [40:36] reg, [35:20] write data, [19:4] expected, [3:0] requirement
    localparam int NV = 46;
    localparam logic [41:0] VEC [NV] = '{
        {1'b0, 5'h0D, 16'h001F, 16'h0000, 4'd3},   // R3 pointer kind
        {1'b0, 5'h0E, 16'h0005, 16'h0000, 4'd3},
        {1'b1, 5'h0E, 16'h0000, 16'h0005, 4'd3},   // R3 pointer readback
        {1'b0, 5'h0D, 16'h401F, 16'h0000, 4'd4},
        {1'b0, 5'h0E, 16'hBEEF, 16'h0000, 4'd4},
        {1'b1, 5'h0E, 16'h0000, 16'hBEEF, 4'd5},   // R5 bank read
        {1'b1, 5'h0E, 16'h0000, 16'hBEEF, 4'd4},   // R4 no advance
        {1'b1, 5'h0D, 16'h0000, 16'h401F, 4'd2},   // R2 readback
        {1'b0, 5'h0D, 16'hFFFF, 16'h0000, 4'd2},
        {1'b1, 5'h0D, 16'h0000, 16'hC01F, 4'd2},   // R2 reserved zero
        {1'b0, 5'h0E, 16'h1111, 16'h0000, 4'd7},   // R7 write advances
        {1'b1, 5'h0E, 16'h0000, 16'hA006, 4'd7},
        {1'b1, 5'h0E, 16'h0000, 16'hA006, 4'd7},   // R7 read holds
        {1'b0, 5'h0E, 16'h2222, 16'h0000, 4'd7},
        {1'b0, 5'h0D, 16'h001F, 16'h0000, 4'd7},
        {1'b1, 5'h0E, 16'h0000, 16'h0007, 4'd7},
        {1'b0, 5'h0E, 16'h0010, 16'h0000, 4'd6},
        {1'b0, 5'h0D, 16'h801F, 16'h0000, 4'd6},
        {1'b1, 5'h0E, 16'h0000, 16'hA010, 4'd6},   // R6 read advances
        {1'b1, 5'h0E, 16'h0000, 16'hA011, 4'd6},
        {1'b0, 5'h0E, 16'h3333, 16'h0000, 4'd6},
        {1'b0, 5'h0D, 16'h001F, 16'h0000, 4'd6},
        {1'b1, 5'h0E, 16'h0000, 16'h0013, 4'd6},
        {1'b0, 5'h0E, 16'hFFFF, 16'h0000, 4'd8},   // R8 wrap
        {1'b0, 5'h0D, 16'hC01F, 16'h0000, 4'd8},
        {1'b0, 5'h0E, 16'h4444, 16'h0000, 4'd8},
        {1'b0, 5'h0D, 16'h401F, 16'h0000, 4'd8},
        {1'b1, 5'h0E, 16'h0000, 16'hA000, 4'd8},
        {1'b0, 5'h0D, 16'h001F, 16'h0000, 4'd8},
        {1'b1, 5'h0E, 16'h0000, 16'h0000, 4'd8},
        {1'b0, 5'h0E, 16'h0020, 16'h0000, 4'd9},   // R9 foreign device
        {1'b0, 5'h0D, 16'h4003, 16'h0000, 4'd9},
        {1'b0, 5'h0E, 16'h5555, 16'h0000, 4'd9},
        {1'b1, 5'h0E, 16'h0000, 16'h0000, 4'd9},
        {1'b0, 5'h0D, 16'h8003, 16'h0000, 4'd9},
        {1'b1, 5'h0E, 16'h0000, 16'h0000, 4'd9},
        {1'b0, 5'h0D, 16'h0003, 16'h0000, 4'd9},
        {1'b0, 5'h0E, 16'h0099, 16'h0000, 4'd9},
        {1'b0, 5'h0D, 16'h401F, 16'h0000, 4'd9},
        {1'b1, 5'h0E, 16'h0000, 16'hA020, 4'd9},
        {1'b0, 5'h0D, 16'h001F, 16'h0000, 4'd9},
        {1'b1, 5'h0E, 16'h0000, 16'h0020, 4'd9},
        {1'b0, 5'h05, 16'hFFFF, 16'h0000, 4'd10},  // R10 other registers
        {1'b1, 5'h05, 16'h0000, 16'h0000, 4'd10},
        {1'b1, 5'h0D, 16'h0000, 16'h001F, 4'd10},
        {1'b1, 5'h0E, 16'h0000, 16'h0020, 4'd10}
    };

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(5'h0D, d);
        check("R1 ctrl", d, 16'h0000);
        check("R1 ptr", ext_addr, 16'h0000);
        check("R1 we", {15'b0, ext_we}, 16'h0000);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][41]) begin
                rd_reg(VEC[k][40:36], d);
                check($sformatf("R%0d vec %0d", VEC[k][3:0], k), d, VEC[k][19:4]);
            end else begin
                wr_reg(VEC[k][40:36], VEC[k][35:20]);
            end
        end

        // R4 bank strobe timing; pointer is 0x0020 here
        wr_reg(5'h0D, 16'h401F);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'h0E; reg_wdata = 16'h7777;
        #2;
        check("R4 we high", {15'b0, ext_we}, 16'h0001);
        check("R4 addr", ext_addr, 16'h0020);
        check("R4 wdata", ext_wdata, 16'h7777);
        @(negedge clk);
        reg_wr = 1'b0;
        #2 check("R4 we low", {15'b0, ext_we}, 16'h0000);
        rd_reg(5'h0E, d);
        check("R4 bank", d, 16'h7777);
        check("R4 ptr held", ext_addr, 16'h0020);

        // R3 pointer-kind write never strobes the bank
        wr_reg(5'h0D, 16'h001F);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'h0E; reg_wdata = 16'h0021;
        #2 check("R3 no we", {15'b0, ext_we}, 16'h0000);
        @(negedge clk);
        reg_wr = 1'b0;
        check("R3 ptr load", ext_addr, 16'h0021);

        // R1 reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd_reg(5'h0D, d);
        check("R1 ctrl after reset", d, 16'h0000);
        check("R1 ptr after reset", ext_addr, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule